// File: doc/BRIEF.md
# Latency-Configurable Dual-Port RAM

This block is a synchronous memory with one write port and one read port that run side by side. Each port has its own pipeline depth, chosen by a parameter: a write is held in a register chain before it is written into the array, and a read request is held in a register chain before it samples the array. Its data then comes out of one final output register together with a valid strobe. A per-write mask bit lets a caller present a write slot that must not change memory.

A read and a write can reach the same entry on the same clock edge: the write commits on that edge and the read samples it. A policy parameter decides what the read returns in that case. The read-first setting returns the contents before the write. The write-first setting forwards the data being written. The read samples the array at the end of its pipeline, so under write-first a read issued two cycles after a write to the same entry returns the new value whenever WR_LAT ≤ RD_LAT + 2.

Top module: `pipeRam`

## Requirements
- R1: A read request sampled with rdEn=1 on clock edge n drives rdValid=1 and its data on rdData in the cycle after edge n+RD_LAT-1, that is RD_LAT edges counting edge n as the first.
- R2: A write sampled with wrEn=1 and wrMask=1 on edge n commits to the array on edge n+WR_LAT-1. A read whose array-sampling edge (its issue edge + RD_LAT-1) comes later than that edge returns the written data.
- R3: When a read samples an entry on the same edge that a write commits to that entry, RUW_MODE=RUW_OLD returns the previous contents and RUW_MODE=RUW_NEW returns the write data.
- R4: A write sampled with wrMask=0 leaves the addressed entry unchanged, even with wrEn=1.
- R5: A write and a read to different addresses in the same cycle both complete: the read returns that address's committed contents.
- R6: With RUW_NEW and WR_LAT ≤ RD_LAT+2, a read issued two cycles after a write to the same address returns the new data.
- R7: An address written twice returns the later value once both writes have committed.
- R8: A cycle with rdEn=0 produces rdValid=0 in its output slot, and rdData keeps its previous value; rdAddr is ignored.
- R9: While rstN is low and after its release, rdValid is 0 until a read reaches the output, and rdData resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset of the pipelines and output |
| wrEn | input | 1 | Write request |
| wrMask | input | 1 | Write mask; 0 suppresses the write |
| wrAddr | input | AW | Write address |
| wrData | input | DW | Write data |
| rdEn | input | 1 | Read request |
| rdAddr | input | AW | Read address |
| rdData | output | DW | Read data, held between valid slots |
| rdValid | output | 1 | High in the slot carrying a read result |

## Verification
The in-flight checks assume that addresses stay below DEPTH and that reset is held for at least one clock edge, so the pending counters start from zero. The stimulus only uses addresses in the 128-entry range and asserts reset for several cycles. One stimulus sequence drives two instances with different latencies and opposite policies. It is arranged so that the write-first instance meets a collision at exactly WR_LAT = RD_LAT+2, and the read-first instance meets one where the read is issued a cycle before the write.

// File: rtl/ramPkg.sv
package ramPkg;
  typedef enum logic {
    RUW_OLD = 1'b0,
    RUW_NEW = 1'b1
  } ruwPolicy_t;

  // strobes from control to datapath
  typedef struct packed {
    logic commitWr;  // a write reaches the array on this edge
    logic sampleRd;  // a read samples the array on this edge
  } ramStrobe_t;
endpackage

// File: rtl/pipeDelay.sv
module pipeDelay #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  generate
    if (STAGES == 0) begin : g_pass
      logic unusedClk;
      assign unusedClk = clk ^ rstN;
      assign dout = din;
    end else begin : g_pipe
      logic [WIDTH-1:0] stage [STAGES];
      always_ff @(posedge clk) begin
        if (!rstN) begin
          for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else begin
          stage[0] <= din;
          for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
      end
      assign dout = stage[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/pipeRamCtrl.sv
module pipeRamCtrl import ramPkg::*; #(
  parameter int RD_LAT = 2,
  parameter int WR_LAT = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrMask,
  input  logic       rdEn,
  output ramStrobe_t stb,
  output logic       rdValid
);
  localparam int CW = $clog2(RD_LAT + WR_LAT + 2) + 1;

  logic wrLive;
  assign wrLive = wrEn & wrMask;

  pipeDelay #(.WIDTH(1), .STAGES(WR_LAT-1)) u_wrEnPipe (
    .clk(clk), .rstN(rstN), .din(wrLive), .dout(stb.commitWr)
  );

  pipeDelay #(.WIDTH(1), .STAGES(RD_LAT-1)) u_rdEnPipe (
    .clk(clk), .rstN(rstN), .din(rdEn), .dout(stb.sampleRd)
  );

  always_ff @(posedge clk) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= stb.sampleRd;
  end

  // in-flight counters, used by the checks below
  logic [CW-1:0] rdPend, wrPend;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPend <= '0;
      wrPend <= '0;
    end else begin
      rdPend <= rdPend + CW'(rdEn) - CW'(rdValid);
      wrPend <= wrPend + CW'(wrLive) - CW'(stb.commitWr);
    end
  end

  AST_RD_INFLIGHT: assert property (@(posedge clk) disable iff (!rstN)
    rdPend <= CW'(RD_LAT)); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> rdPend != '0); // R8
  AST_WR_INFLIGHT: assert property (@(posedge clk) disable iff (!rstN)
    wrPend <= CW'(WR_LAT - 1)); // R2
  AST_COMMIT_BACKED: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commitWr && WR_LAT > 1) |-> wrPend != '0); // R4
endmodule

// File: rtl/pipeRamData.sv
module pipeRamData import ramPkg::*; #(
  parameter int         DEPTH    = 128,
  parameter int         DW       = 8,
  parameter int         RD_LAT   = 2,
  parameter int         WR_LAT   = 2,
  parameter ruwPolicy_t RUW_MODE = RUW_NEW,
  localparam int        AW       = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  ramStrobe_t    stb,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData
);
  logic [DW-1:0]    mem [DEPTH];
  logic [AW+DW-1:0] wrBundle;
  logic [AW-1:0]    wAddrQ, rAddrQ;
  logic [DW-1:0]    wDataQ;
  logic             hit;

  pipeDelay #(.WIDTH(AW+DW), .STAGES(WR_LAT-1)) u_wrPipe (
    .clk(clk), .rstN(rstN), .din({wrAddr, wrData}), .dout(wrBundle)
  );
  assign {wAddrQ, wDataQ} = wrBundle;

  pipeDelay #(.WIDTH(AW), .STAGES(RD_LAT-1)) u_rdPipe (
    .clk(clk), .rstN(rstN), .din(rdAddr), .dout(rAddrQ)
  );

  assign hit = stb.commitWr && (wAddrQ == rAddrQ);

  always_ff @(posedge clk) begin
    if (stb.commitWr) mem[wAddrQ] <= wDataQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (stb.sampleRd) begin
      if (RUW_MODE == RUW_NEW && hit) rdData <= wDataQ;
      else                            rdData <= mem[rAddrQ];
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.sampleRd |=> $stable(rdData)); // R8
endmodule

// File: rtl/pipeRam.sv
module pipeRam import ramPkg::*; #(
  parameter int         DEPTH    = 128,
  parameter int         DW       = 8,
  parameter int         RD_LAT   = 2,
  parameter int         WR_LAT   = 2,
  parameter ruwPolicy_t RUW_MODE = RUW_NEW,
  localparam int        AW       = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          wrMask,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          rdEn,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData,
  output logic          rdValid
);
  ramStrobe_t stb;

  pipeRamCtrl #(.RD_LAT(RD_LAT), .WR_LAT(WR_LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrMask(wrMask), .rdEn(rdEn),
    .stb(stb), .rdValid(rdValid)
  );

  pipeRamData #(.DEPTH(DEPTH), .DW(DW), .RD_LAT(RD_LAT), .WR_LAT(WR_LAT),
                .RUW_MODE(RUW_MODE)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: tb/pipeRam_tb.sv
`timescale 1ns/1ps
module pipeRam_tb;
  import ramPkg::*;
  localparam int NMAX = 256;
  localparam int RL [2] = '{2, 3};
  localparam int WL [2] = '{4, 2};
  localparam bit NP [2] = '{1'b1, 1'b0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 0, wrMask = 0, rdEn = 0;
  logic [6:0] wrAddr = '0, rdAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] dataN, dataO;
  logic validN, validO;

  always #4 clk = ~clk;

  // write-first, WR_LAT = RD_LAT + 2
  pipeRam #(.DEPTH(128), .DW(8), .RD_LAT(2), .WR_LAT(4), .RUW_MODE(RUW_NEW)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrMask(wrMask), .wrAddr(wrAddr),
    .wrData(wrData), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(dataN), .rdValid(validN));
  // read-first
  pipeRam #(.DEPTH(128), .DW(8), .RD_LAT(3), .WR_LAT(2), .RUW_MODE(RUW_OLD)) u_dutOld (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrMask(wrMask), .wrAddr(wrAddr),
    .wrData(wrData), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(dataO), .rdValid(validO));

  int nChecks = 0, nErrors = 0;
  int nSlots = 0;
  bit sWe [NMAX], sWm [NMAX], sRe [NMAX];
  logic [6:0] sWa [NMAX], sRa [NMAX];
  logic [7:0] sWd [NMAX];
  string sTag [NMAX];
  logic [7:0] mdl [2][128];
  logic [7:0] expD [2];
  bit expV [2];
  string expTag [2];

  task automatic addSlot(bit we, bit wm, int wa, int wd, bit re, int ra, string tag);
    sWe[nSlots] = we; sWm[nSlots] = wm; sWa[nSlots] = 7'(wa); sWd[nSlots] = 8'(wd);
    sRe[nSlots] = re; sRa[nSlots] = 7'(ra); sTag[nSlots] = tag;
    nSlots++;
  endtask

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // reference model for edge k of instance d
  task automatic modelEdge(int k, int d);
    int ri = k - RL[d] + 1;
    int wi = k - WL[d] + 1;
    bit commit = (wi >= 0 && wi < nSlots) && sWe[wi] && sWm[wi];
    bit rd = (ri >= 0 && ri < nSlots) && sRe[ri];
    if (NP[d] && commit) mdl[d][sWa[wi]] = sWd[wi];
    expV[d] = rd;
    if (rd) begin
      expD[d] = mdl[d][sRa[ri]];
      expTag[d] = sTag[ri];
    end else begin
      expTag[d] = "R8";
    end
    if (!NP[d] && commit) mdl[d][sWa[wi]] = sWd[wi];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    // sweep: write every entry, read the entry written 8 slots back
    for (int a = 0; a < 128; a++)
      addSlot(1, 1, a, (a*7+3) & 255, a >= 8, a - 8, "R5");
    for (int i = 0; i < 4; i++) addSlot(0, 0, 0, 0, 0, i*13, "R8");
    addSlot(1, 1, 10, 8'hA5, 0, 0, "R8");
    addSlot(0, 0, 0, 0, 0, 0, "R8");
    addSlot(0, 0, 0, 0, 1, 10, "R6");
    addSlot(0, 0, 0, 0, 1, 20, "R3");
    addSlot(1, 1, 20, 8'h3C, 0, 0, "R8");
    addSlot(0, 0, 0, 0, 0, 0, "R8");
    addSlot(0, 0, 0, 0, 1, 20, "R2");
    addSlot(1, 0, 30, 8'hFF, 1, 31, "R5");
    for (int i = 0; i < 4; i++) addSlot(0, 0, 0, 0, 0, 30, "R8");
    addSlot(0, 0, 0, 0, 1, 30, "R4");
    addSlot(1, 1, 40, 8'h11, 0, 0, "R8");
    addSlot(1, 1, 40, 8'h22, 0, 0, "R8");
    for (int i = 0; i < 5; i++) addSlot(0, 0, 0, 0, 0, 0, "R8");
    addSlot(0, 0, 0, 0, 1, 40, "R7");
    addSlot(0, 0, 0, 0, 1, 0, "R1");
    addSlot(0, 0, 0, 0, 1, 127, "R1");

    for (int d = 0; d < 2; d++) begin
      expD[d] = '0;
      expV[d] = 1'b0;
      for (int a = 0; a < 128; a++) mdl[d][a] = '0;
    end

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(validN == 1'b0, "R9", "reset rdValid new", int'(validN), 0);
    chk(validO == 1'b0, "R9", "reset rdValid old", int'(validO), 0);
    chk(dataN == 8'h00, "R9", "reset rdData new", int'(dataN), 0);
    chk(dataO == 8'h00, "R9", "reset rdData old", int'(dataO), 0);
    rstN = 1'b1;

    for (int k = 0; k < nSlots + 6; k++) begin
      if (k < nSlots) begin
        wrEn = sWe[k]; wrMask = sWm[k]; wrAddr = sWa[k]; wrData = sWd[k];
        rdEn = sRe[k]; rdAddr = sRa[k];
      end else begin
        wrEn = 0; wrMask = 0; rdEn = 0; rdAddr = 7'(k);
      end
      @(posedge clk);
      modelEdge(k, 0);
      modelEdge(k, 1);
      @(negedge clk);
      chk(validN == expV[0], expTag[0], "rdValid new", int'(validN), int'(expV[0]));
      chk(dataN == expD[0], expTag[0], "rdData new", int'(dataN), int'(expD[0]));
      chk(validO == expV[1], expTag[1], "rdValid old", int'(validO), int'(expV[1]));
      chk(dataO == expD[1], expTag[1], "rdData old", int'(dataO), int'(expD[1]));
    end

    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule